// File: doc/BRIEF.md
# Edge-Started Byte-Wide Parallel Memory

This block models a byte-wide parallel memory whose accesses do not follow the address bus. An access opens only when the active-low chip enable goes from high to low. At that moment the address is captured. For the rest of the access, the active-low output enable and write enable act on the captured location. Before the next address can be taken, the chip enable must return high for a precharge interval. This differs from a plain asynchronous SRAM, which tracks its address continuously.

All three control strobes are synchronised to the system clock and edge-detected there. The read access time is modelled as a parameterised number of clock cycles. A write lands in the array at once, with no busy state. The precharge interval is enforced as a parameterised count of cycles. A chip enable that falls too early opens no access and sets a sticky violation flag. Reset returns the control state, the latched address and the flags to idle. It leaves the stored bytes untouched.

The data bus is split into a data input, a data output and a drive-enable. The default build uses 12 address bits (4096 bytes). Setting `ADDR_W` to 15 gives the full 32,768 x 8 organisation.

Top module: `celm_top`

## Requirements
- R1: The array holds 2**ADDR_W bytes. A byte written to one address is read back from that address, independent of the other addresses.
- R2: The address is sampled only when the synchronised chip enable falls. Changes on `addr` while chip enable stays low do not move the access.
- R3: A chip-enable fall counts only if the synchronised chip enable was high for at least PRECHARGE_CYC cycles (default 4) beforehand. A fall after a shorter high time opens no access: no write, no read data, no drive. It also sets `pre_viol`, which stays at 1 until reset.
- R4: Suppose `ce_n` and `oe_n` fall together in a cycle where the precharge is met. Then `data_valid` and the read byte on `dout` first appear after the (SYNC_STAGES + 2 + READ_LAT)-th rising edge, which is the 8th edge with the defaults. They are absent after the edge before it.
- R5: `dq_oe` is 1 only during an accepted access with valid data, `oe_n` low and `we_n` high. It drops within SYNC_STAGES edges of `oe_n` rising, while `data_valid` stays 1.
- R6: While an accepted access has `we_n` low, `din` is written to the latched address. The new byte can be read back within the same chip-enable-low access, with no completion delay.
- R7: When `we_n` and `oe_n` are both low, the write is performed and `dq_oe` stays 0.
- R8: `dout` holds its value while no new read is loaded, including across an `oe_n` high-then-low excursion. `data_valid` clears SYNC_STAGES + 1 edges after `ce_n` rises.
- R9: Reset clears `data_valid`, `dq_oe`, `pre_viol` and `dout`. The memory contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Active-low chip enable; its falling edge starts an access |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Byte address, captured on the chip-enable fall |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, held between loads |
| dq_oe | output | 1 | Drive enable for the external data bus |
| data_valid | output | 1 | Read data in `dout` belongs to the current access |
| pre_viol | output | 1 | Sticky flag: a chip-enable fall came before the precharge was met |

## Verification
Each control strobe passes through SYNC_STAGES flops before the control logic sees it. Chip-enable edges add one more flop. The bench therefore expects a read's `data_valid` exactly at edge SYNC_STAGES + 2 + READ_LAT after the strobes fall, and checks that the edge before shows nothing. It expects `dq_oe` to follow `oe_n` after SYNC_STAGES edges and `data_valid` to clear SYNC_STAGES + 1 edges after `ce_n` rises, testing each on both sides of its edge. The precharge boundary is checked with exactly PRECHARGE_CYC high cycles, which is accepted, and one cycle fewer, which is rejected. Inputs are driven and outputs sampled on the falling clock edge.

// File: rtl/celm_pkg.sv
package celm_pkg;
  typedef enum logic [1:0] {
    CY_IDLE   = 2'd0,
    CY_ACTIVE = 2'd1,
    CY_REJECT = 2'd2
  } cyc_state_t;
endpackage

// File: rtl/celm_rst_sync.sv
module celm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/celm_sync.sv
module celm_sync #(
  parameter int          STAGES  = 2,
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [W-1:0] stg_in;
    if (i == 0) begin : g_first
      assign stg_in = d;
    end else begin : g_next
      assign stg_in = stg[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg_in;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/celm_cycle_ctrl.sv
module celm_cycle_ctrl
  import celm_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int PRECHARGE_CYC = 4,
  parameter int READ_LAT      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              oe_s,
  input  logic              we_s,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_lat,
  output logic              active,
  output logic              ce_fall,
  output logic              ce_rise,
  output logic              wr_en,
  output logic              rd_load,
  output logic              data_valid,
  output logic              dq_drive,
  output logic              pre_viol
);
  localparam int PC_W = $clog2(PRECHARGE_CYC + 2);
  localparam int RL_W = $clog2(READ_LAT + 2);
  localparam logic [PC_W-1:0] PC_MAX = PC_W'(PRECHARGE_CYC);
  localparam logic [RL_W-1:0] RL_MAX = RL_W'(READ_LAT);

  cyc_state_t        state_q, state_nx;
  logic              ce_q;
  logic [PC_W-1:0]   pc_cnt_q, pc_cnt_nx;
  logic [RL_W-1:0]   rd_cnt_q, rd_cnt_nx;
  logic [ADDR_W-1:0] addr_nx;
  logic              valid_nx, viol_nx;
  logic              pc_ok, rd_ready, accept;

  assign ce_fall  = ce_q & ~ce_s;
  assign ce_rise  = ~ce_q & ce_s;
  assign pc_ok    = (pc_cnt_q >= PC_MAX);
  assign accept   = ce_fall & pc_ok;
  assign active   = (state_q == CY_ACTIVE);
  assign rd_ready = (rd_cnt_q == RL_MAX);
  assign wr_en    = active & ~ce_s & ~we_s;
  assign rd_load  = active & ~ce_s & we_s & ~oe_s & rd_ready;
  assign dq_drive = active & data_valid & we_s & ~oe_s;

  always_comb begin
    state_nx  = state_q;
    pc_cnt_nx = pc_cnt_q;
    rd_cnt_nx = rd_cnt_q;
    addr_nx   = addr_lat;
    valid_nx  = data_valid;
    viol_nx   = pre_viol;

    if (ce_s) begin
      if (!pc_ok) pc_cnt_nx = pc_cnt_q + 1'b1;
    end else begin
      pc_cnt_nx = '0;
    end

    if (ce_s) begin
      state_nx = CY_IDLE;
    end else if (ce_fall) begin
      state_nx = pc_ok ? CY_ACTIVE : CY_REJECT;
    end

    if (accept) addr_nx = addr_in;
    if (ce_fall && !pc_ok) viol_nx = 1'b1;

    if (accept) begin
      rd_cnt_nx = '0;
    end else if (active && !rd_ready) begin
      rd_cnt_nx = rd_cnt_q + 1'b1;
    end

    if (ce_s) begin
      valid_nx = 1'b0;
    end else if (rd_load) begin
      valid_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= CY_IDLE;
      ce_q       <= 1'b1;
      pc_cnt_q   <= '0;
      rd_cnt_q   <= '0;
      addr_lat   <= '0;
      data_valid <= 1'b0;
      pre_viol   <= 1'b0;
    end else begin
      state_q    <= state_nx;
      ce_q       <= ce_s;
      pc_cnt_q   <= pc_cnt_nx;
      rd_cnt_q   <= rd_cnt_nx;
      addr_lat   <= addr_nx;
      data_valid <= valid_nx;
      pre_viol   <= viol_nx;
    end
  end
endmodule

// File: rtl/celm_array.sv
module celm_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[addr];
  end
endmodule

// File: rtl/celm_top.sv
module celm_top #(
  parameter int ADDR_W        = 12,
  parameter int DATA_W        = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int PRECHARGE_CYC = 4,
  parameter int READ_LAT      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dq_oe,
  output logic              data_valid,
  output logic              pre_viol
);
  logic              rst_sync_n;
  logic [2:0]        strobe_s;
  logic              ce_s, oe_s, we_s;
  logic [ADDR_W-1:0] addr_lat;
  logic              active, ce_fall, ce_rise, wr_en, rd_load;

  celm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  celm_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b111)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({ce_n, oe_n, we_n}),
    .q     (strobe_s)
  );

  assign {ce_s, oe_s, we_s} = strobe_s;

  celm_cycle_ctrl #(
    .ADDR_W(ADDR_W), .PRECHARGE_CYC(PRECHARGE_CYC), .READ_LAT(READ_LAT)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ce_s       (ce_s),
    .oe_s       (oe_s),
    .we_s       (we_s),
    .addr_in    (addr),
    .addr_lat   (addr_lat),
    .active     (active),
    .ce_fall    (ce_fall),
    .ce_rise    (ce_rise),
    .wr_en      (wr_en),
    .rd_load    (rd_load),
    .data_valid (data_valid),
    .dq_drive   (dq_oe),
    .pre_viol   (pre_viol)
  );

  celm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .rd_en   (rd_load),
    .addr    (addr_lat),
    .wr_data (din),
    .rd_data (dout)
  );
endmodule

// File: rtl/celm_checker.sv
module celm_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_s,
  input logic              active,
  input logic              ce_fall,
  input logic              ce_rise,
  input logic [ADDR_W-1:0] addr_lat,
  input logic              wr_en,
  input logic              rd_load,
  input logic              data_valid,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dout,
  input logic              pre_viol
);
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ce_s) |=> $stable(addr_lat)); // R2

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pre_viol |=> pre_viol); // R3

  AST_VIOL_FROM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pre_viol) |-> $past(ce_fall)); // R3

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !dq_oe); // R5

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !dq_oe); // R7

  AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ce_rise |=> !data_valid); // R8

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_load |=> $stable(dout)); // R8
endmodule

bind celm_top celm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .ce_s       (ce_s),
  .active     (active),
  .ce_fall    (ce_fall),
  .ce_rise    (ce_rise),
  .addr_lat   (addr_lat),
  .wr_en      (wr_en),
  .rd_load    (rd_load),
  .data_valid (data_valid),
  .dq_oe      (dq_oe),
  .dout       (dout),
  .pre_viol   (pre_viol)
);

// File: tb/celm_top_test.sv
module celm_top_test;
  localparam int AW  = 12;
  localparam int DW  = 8;
  localparam int RL  = 4;
  localparam int SYN = 2;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b1, 12'h000, 8'h00},
    '{1'b1, 12'hFFF, 8'hFF},
    '{1'b1, 12'h001, 8'hA5},
    '{1'b1, 12'h800, 8'h5A},
    '{1'b1, 12'h005, 8'h3C},
    '{1'b0, 12'h000, 8'h00},
    '{1'b0, 12'hFFF, 8'hFF},
    '{1'b0, 12'h001, 8'hA5},
    '{1'b0, 12'h800, 8'h5A},
    '{1'b1, 12'h006, 8'hC3}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, we_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dq_oe, data_valid, pre_viol;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  celm_top uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dq_oe(dq_oe),
    .data_valid(data_valid), .pre_viol(pre_viol)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; ce_n = 1'b0;
    wait_n(4);
    din = d; we_n = 1'b0;
    wait_n(4);
    we_n = 1'b1;
    wait_n(3);
    ce_n = 1'b1;
    wait_n(8);
  endtask

  task automatic rd_byte(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    wait_n(RL + 8);
    d = dout; v = data_valid;
    ce_n = 1'b1; oe_n = 1'b1;
    wait_n(8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    logic          rv;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    addr = '0; din = '0;
    wait_n(5);
    check("R9 reset data_valid", data_valid, 0);
    check("R9 reset dq_oe", dq_oe, 0);
    check("R9 reset pre_viol", pre_viol, 0);
    check("R9 reset dout", dout, 0);
    rst_n = 1'b1;
    wait_n(8);

    // R1 table walk: writes then read-backs at spread addresses
    for (int i = 0; i < 10; i++) begin
      if (VECS[i].wr) begin
        wr_byte(VECS[i].a, VECS[i].d);
      end else begin
        rd_byte(VECS[i].a, rd, rv);
        check("R1 read-back data", rd, VECS[i].d);
        check("R1 read-back valid", rv, 1);
      end
    end

    // R4 exact read latency
    @(negedge clk);
    addr = 12'h005; ce_n = 1'b0; oe_n = 1'b0;
    wait_n(SYN + 1 + RL);
    check("R4 not valid one edge early", data_valid, 0);
    wait_n(1);
    check("R4 valid on due edge", data_valid, 1);
    check("R4 data on due edge", dout, 8'h3C);
    check("R5 drive while reading", dq_oe, 1);

    // R5 OE high stops drive, valid kept
    oe_n = 1'b1;
    wait_n(SYN - 1);
    check("R5 drive before oe sync", dq_oe, 1);
    wait_n(1);
    check("R5 drive off after oe high", dq_oe, 0);
    check("R5 valid kept with oe high", data_valid, 1);
    oe_n = 1'b0;
    wait_n(SYN);
    check("R8 dout held across oe excursion", dout, 8'h3C);
    check("R5 drive back on", dq_oe, 1);

    // R2 address change while CE low is ignored
    addr = 12'h006;
    wait_n(4);
    check("R2 latched address kept", dout, 8'h3C);

    // R8 valid clears on CE rise
    ce_n = 1'b1;
    wait_n(SYN);
    check("R8 valid before rise seen", data_valid, 1);
    wait_n(1);
    check("R8 valid cleared after rise", data_valid, 0);
    check("R8 drive off after rise", dq_oe, 0);
    oe_n = 1'b1;
    wait_n(8);

    // R6 write then read back in the same CE-low access
    addr = 12'h007; ce_n = 1'b0;
    wait_n(4);
    din = 8'h77; we_n = 1'b0;
    wait_n(4);
    we_n = 1'b1; oe_n = 1'b0;
    wait_n(SYN + 2);
    check("R6 same-access read data", dout, 8'h77);
    check("R6 same-access read valid", data_valid, 1);
    ce_n = 1'b1; oe_n = 1'b1;
    wait_n(8);

    // R7 write priority over read
    addr = 12'h008; ce_n = 1'b0;
    wait_n(3);
    oe_n = 1'b0; we_n = 1'b0; din = 8'h88;
    wait_n(RL + 6);
    check("R7 no drive while writing", dq_oe, 0);
    check("R7 no valid while writing", data_valid, 0);
    we_n = 1'b1;
    wait_n(SYN + 2);
    check("R7 written byte readable", dout, 8'h88);
    check("R7 drive after write ends", dq_oe, 1);
    ce_n = 1'b1; oe_n = 1'b1;
    wait_n(8);

    // R3 precharge boundary: exactly PRECHARGE_CYC high cycles accepted
    ce_n = 1'b0;
    wait_n(6);
    ce_n = 1'b1;
    wait_n(4);
    addr = 12'h005; ce_n = 1'b0; oe_n = 1'b0;
    wait_n(RL + 8);
    check("R3 boundary accepted valid", data_valid, 1);
    check("R3 boundary accepted data", dout, 8'h3C);
    check("R3 boundary no violation", pre_viol, 0);
    ce_n = 1'b1; oe_n = 1'b1;
    wait_n(3);

    // R3 one cycle short: ignored, flag set
    addr = 12'h005; ce_n = 1'b0; we_n = 1'b0; din = 8'hEE;
    wait_n(6);
    check("R3 short precharge flagged", pre_viol, 1);
    we_n = 1'b1; oe_n = 1'b0;
    wait_n(RL + 6);
    check("R3 rejected access no data", data_valid, 0);
    check("R3 rejected access no drive", dq_oe, 0);
    ce_n = 1'b1; oe_n = 1'b1;
    wait_n(8);
    rd_byte(12'h005, rd, rv);
    check("R3 rejected write had no effect", rd, 8'h3C);
    check("R3 flag sticky after good access", pre_viol, 1);

    // R9 reset clears flags but keeps memory
    rst_n = 1'b0;
    wait_n(3);
    check("R9 reset clears pre_viol", pre_viol, 0);
    check("R9 reset clears data_valid", data_valid, 0);
    check("R9 reset clears dout", dout, 0);
    rst_n = 1'b1;
    wait_n(8);
    rd_byte(12'h006, rd, rv);
    check("R9 memory kept across reset", rd, 8'hC3);
    rd_byte(12'hFFF, rd, rv);
    check("R9 top address kept across reset", rd, 8'hFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule